// File: doc/BRIEF.md
# Extended Format Target Address Unit

This unit sits behind instruction fetch on a machine with a 20-bit byte address space. It takes up to four instruction bytes, the address of the instruction, and the current base and index register values. From these it works out how long the instruction is and which flags it carries. For the 3-byte and 4-byte formats it also computes the effective target address. When the addressing flags call for a level of indirection, the unit reads a 3-byte word from memory through a simple request/grant byte port and uses that word as the final address.

Instructions enter on a valid/ready stream. The unit holds one instruction at a time. `in_ready` is high only while the unit is empty, so an upstream stage must keep `in_valid` and its data steady until it sees `in_ready`. Results leave on a second valid/ready stream. Once `out_valid` rises, every result field stays fixed until the cycle in which `out_ready` is also high. The unit accepts the next instruction only after that transfer. Operand fetch and execution belong to later stages.

Top module: `tgt_addr_unit`

## Requirements
- R1: The instruction length `out_len` is 1 when opcode byte `in_bytes[31:24]` is one of 0xC0, 0xC4, 0xC8, 0xF0, 0xF4 or 0xF8. It is 2 when the opcode byte is one of 0x90, 0x94, 0x98, 0x9C, 0xA0, 0xA4, 0xA8, 0xAC, 0xB0, 0xB4 or 0xB8. Otherwise it is 3 when flag e is 0 and 4 when e is 1.
- R2: For a 2-byte instruction, `out_r1` is `in_bytes[23:20]` and `out_r2` is `in_bytes[19:16]`. For 1-byte and 2-byte instructions, `out_ta`, `out_mode` and `out_flags` are zero. For all other formats, `out_r1` and `out_r2` are zero.
- R3: For 3-byte and 4-byte instructions, the flags are n=`in_bytes[25]`, i=`in_bytes[24]`, x=`in_bytes[23]`, b=`in_bytes[22]`, p=`in_bytes[21]` and e=`in_bytes[20]`. They are reported as `out_flags` = {n,i,x,b,p,e}. The field is `in_bytes[19:8]` (12 bits) when e=0 and `in_bytes[19:0]` (20 bits) when e=1.
- R4: When b=1 and p=0, the target is `reg_b` plus the field, taken as unsigned.
- R5: When p=1 and b=0, the target is the next instruction address (`in_pc` + length) plus the field. A 12-bit field is sign-extended; a 20-bit field is added as it is.
- R6: When b and p are equal (both 0 or both 1), the field itself is the target.
- R7: When x=1, `reg_x` is added to the target. All target arithmetic wraps modulo 2^20.
- R8: `out_mode` = {n,i}: 00 simple, 01 immediate, 10 indirect, 11 normal. Only mode 10 makes any memory request. In the other modes `out_ta` is the computed target.
- R9: In indirect mode the unit reads bytes at target, target+1 and target+2 (wrapping at 2^20), most significant byte first. `out_ta` is the low 20 bits of the 24-bit word read.
- R10: A byte read is accepted at a rising edge where `mem_req` and `mem_gnt` are both high. Its data is taken from `mem_rdata` at the edge RD_LAT cycles later. While `mem_req` is high and not granted, `mem_addr` is held.
- R11: `in_ready` is high only while no instruction is held. `out_valid` and all result fields stay stable until they are taken with `out_ready`.
- R12: For every mode except indirect, `out_valid` is high in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction bytes valid |
| in_ready | output | 1 | Unit can accept an instruction |
| in_bytes | input | 32 | Instruction bytes, first byte in [31:24] |
| in_pc | input | ADDR_W | Address of the instruction |
| reg_b | input | ADDR_W | Base register value |
| reg_x | input | ADDR_W | Index register value |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_len | output | 3 | Instruction length in bytes |
| out_mode | output | 2 | Operand mode {n,i} |
| out_flags | output | 6 | {n,i,x,b,p,e} |
| out_r1 | output | 4 | First register field |
| out_r2 | output | 4 | Second register field |
| out_ta | output | ADDR_W | Final target address |
| mem_req | output | 1 | Byte read request |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | Byte read address |
| mem_rdata | input | 8 | Read data, RD_LAT cycles after grant |

## Verification
A non-indirect result is due one cycle after the accepting edge. The bench checks `out_valid` at the falling edge that follows the accept, and a bound property checks the same timing. An indirect result is due only after three granted reads, each adding RD_LAT cycles plus whatever grant stall the bench applies. For that reason the bench compares results when the output handshake happens, not at a fixed cycle. The bench memory model returns each byte exactly RD_LAT edges after the grant, so a unit that samples `mem_rdata` in the wrong cycle, or at the wrong address, produces a wrong target. The bench also counts granted reads per instruction to confirm that only indirect mode touches memory.

// File: rtl/tau_pkg.sv
package tau_pkg;
  localparam int FIELD_W = 20;
  localparam int WORD_BYTES = 3;

  typedef enum logic [1:0] {
    AM_SIMPLE = 2'b00,
    AM_IMMED  = 2'b01,
    AM_INDIR  = 2'b10,
    AM_NORMAL = 2'b11
  } amode_e;

  typedef struct packed {
    logic n;
    logic i;
    logic x;
    logic b;
    logic p;
    logic e;
  } flags_t;

  // single-byte opcode set: Cx and Fx rows, steps of 4, first three columns
  function automatic logic is_one_byte(input logic [7:0] op);
    return (op[1:0] == 2'b00) && (op[3:2] != 2'b11) &&
           ((op[7:4] == 4'hC) || (op[7:4] == 4'hF));
  endfunction

  // two-byte opcode set: 0x90 through 0xB8 in steps of 4
  function automatic logic is_two_byte(input logic [7:0] op);
    return (op[1:0] == 2'b00) && (op >= 8'h90) && (op <= 8'hB8);
  endfunction
endpackage

// File: rtl/tau_decode.sv
module tau_decode
  import tau_pkg::*;
(
  input  logic [31:0]        ins,
  output logic [2:0]         len,
  output logic               short_fmt,
  output flags_t             flg,
  output logic [3:0]         r1,
  output logic [3:0]         r2,
  output logic [11:0]        f12,
  output logic [FIELD_W-1:0] f20
);
  logic [7:0] op;
  logic       one_b;
  logic       two_b;

  assign op    = ins[31:24];
  assign one_b = is_one_byte(op);
  assign two_b = is_two_byte(op);
  assign f12   = ins[19:8];
  assign f20   = ins[19:0];

  always_comb begin
    short_fmt = one_b || two_b;
    flg       = '0;
    r1        = '0;
    r2        = '0;
    if (one_b) begin
      len = 3'd1;
    end else if (two_b) begin
      len = 3'd2;
      r1  = ins[23:20];
      r2  = ins[19:16];
    end else begin
      flg = '{n: op[1], i: op[0], x: ins[23], b: ins[22], p: ins[21], e: ins[20]};
      len = ins[20] ? 3'd4 : 3'd3;
    end
  end
endmodule

// File: rtl/tau_addr_calc.sv
module tau_addr_calc
  import tau_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  flags_t             flg,
  input  logic [2:0]         len,
  input  logic [11:0]        f12,
  input  logic [FIELD_W-1:0] f20,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [ADDR_W-1:0]  base_reg,
  input  logic [ADDR_W-1:0]  index_reg,
  output logic [ADDR_W-1:0]  ta
);
  logic [ADDR_W-1:0] next_pc;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] idx;

  assign next_pc = pc + ADDR_W'(len);
  assign idx     = flg.x ? index_reg : '0;

  always_comb begin
    base = '0;
    off  = flg.e ? ADDR_W'(f20) : ADDR_W'(f12);
    if (flg.b && !flg.p) begin
      base = base_reg;
    end else if (flg.p && !flg.b) begin
      base = next_pc;
      if (!flg.e) off = ADDR_W'($signed(f12));
    end
  end

  assign ta = base + off + idx;
endmodule

// File: rtl/tau_ind_fetch.sv
module tau_ind_fetch
  import tau_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              done,
  output logic [ADDR_W-1:0] word,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);
  localparam int CW = $clog2(RD_LAT + 1);
  localparam int IW = $clog2(WORD_BYTES + 1);

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fst_e;

  fst_e              st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [ADDR_W-1:0] addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= F_IDLE;
      cnt  <= '0;
      idx  <= '0;
      addr <= '0;
      word <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        F_IDLE: if (start) begin
          addr <= start_addr;
          idx  <= '0;
          st   <= F_REQ;
        end
        F_REQ: if (mem_gnt) begin
          cnt <= CW'(RD_LAT);
          st  <= F_WAIT;
        end
        F_WAIT: begin
          if (cnt == CW'(1)) begin
            word <= {word[ADDR_W-9:0], mem_rdata};
            if (idx == IW'(WORD_BYTES - 1)) begin
              done <= 1'b1;
              st   <= F_IDLE;
            end else begin
              idx  <= idx + IW'(1);
              addr <= addr + ADDR_W'(1);
              st   <= F_REQ;
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assign mem_req  = (st == F_REQ);
  assign mem_addr = addr;
endmodule

// File: rtl/tgt_addr_unit.sv
module tgt_addr_unit
  import tau_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_bytes,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [ADDR_W-1:0] reg_b,
  input  logic [ADDR_W-1:0] reg_x,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_len,
  output logic [1:0]        out_mode,
  output logic [5:0]        out_flags,
  output logic [3:0]        out_r1,
  output logic [3:0]        out_r2,
  output logic [ADDR_W-1:0] out_ta,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_OUT} st_e;

  st_e               st;
  logic [2:0]        d_len;
  logic              d_short;
  flags_t            d_flg;
  logic [3:0]        d_r1;
  logic [3:0]        d_r2;
  logic [11:0]       d_f12;
  logic [FIELD_W-1:0] d_f20;
  logic [ADDR_W-1:0] c_ta;
  logic              accept;
  logic              go_ind;
  logic              f_done;
  logic [ADDR_W-1:0] f_word;

  tau_decode u_dec (
    .ins(in_bytes), .len(d_len), .short_fmt(d_short), .flg(d_flg),
    .r1(d_r1), .r2(d_r2), .f12(d_f12), .f20(d_f20)
  );

  tau_addr_calc #(.ADDR_W(ADDR_W)) u_calc (
    .flg(d_flg), .len(d_len), .f12(d_f12), .f20(d_f20),
    .pc(in_pc), .base_reg(reg_b), .index_reg(reg_x), .ta(c_ta)
  );

  assign in_ready  = (st == S_IDLE);
  assign out_valid = (st == S_OUT);
  assign accept    = in_valid && in_ready;
  assign go_ind    = accept && !d_short && d_flg.n && !d_flg.i;

  tau_ind_fetch #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(go_ind), .start_addr(c_ta),
    .done(f_done), .word(f_word),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      out_len   <= '0;
      out_mode  <= '0;
      out_flags <= '0;
      out_r1    <= '0;
      out_r2    <= '0;
      out_ta    <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          out_len   <= d_len;
          out_mode  <= {d_flg.n, d_flg.i};
          out_flags <= d_flg;
          out_r1    <= d_r1;
          out_r2    <= d_r2;
          out_ta    <= d_short ? '0 : c_ta;
          st        <= go_ind ? S_FETCH : S_OUT;
        end
        S_FETCH: if (f_done) begin
          out_ta <= f_word;
          st     <= S_OUT;
        end
        S_OUT: if (out_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tau_checker.sv
module tau_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [31:0]       in_bytes,
  input logic              out_valid,
  input logic              out_ready,
  input logic [2:0]        out_len,
  input logic [1:0]        out_mode,
  input logic [5:0]        out_flags,
  input logic [ADDR_W-1:0] out_ta,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr
);
  a_r1_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len >= 3'd1 && out_len <= 3'd4));

  a_r8_no_req_while_out: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_req);

  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_ta) && $stable(out_len) && $stable(out_mode) && $stable(out_flags)));

  a_r11_single: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid && !mem_req));

  a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_bytes[25:24] != 2'b10) |=> out_valid);
endmodule

bind tgt_addr_unit tau_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_bytes(in_bytes), .out_valid(out_valid), .out_ready(out_ready),
  .out_len(out_len), .out_mode(out_mode), .out_flags(out_flags), .out_ta(out_ta),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr)
);

// File: tb/sim_tgt_addr_unit.sv
module sim_tgt_addr_unit;
  localparam int AW  = 20;
  localparam int LAT = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   in_bytes = '0;
  logic [AW-1:0] in_pc = '0, reg_b = '0, reg_x = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [2:0]    out_len;
  logic [1:0]    out_mode;
  logic [5:0]    out_flags;
  logic [3:0]    out_r1, out_r2;
  logic [AW-1:0] out_ta;
  logic          mem_req;
  logic          mem_gnt = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata;

  tgt_addr_unit #(.ADDR_W(AW), .RD_LAT(LAT)) u0 (.*);

  int n_cmp = 0;
  int n_bad = 0;
  int mem_acc = 0;
  int acc_mark = 0;

  typedef struct {
    logic [2:0]    len;
    logic [1:0]    mode;
    logic [5:0]    fl;
    logic [3:0]    r1, r2;
    logic [AW-1:0] ta;
    int            reads;
    string         tag;
  } exp_t;
  exp_t q[$];

  function automatic logic [7:0] mb(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[11:8], a[19:16]} ^ 8'h3C;
  endfunction

  function automatic exp_t model(input logic [31:0] ib, input logic [AW-1:0] pc,
                                 input logic [AW-1:0] b, input logic [AW-1:0] x);
    exp_t r;
    logic [7:0] op, b1;
    logic n, i, xx, bb, p, e;
    logic [11:0] f12;
    logic [AW-1:0] off, base, ta;
    logic [23:0] w;
    op = ib[31:24]; b1 = ib[23:16];
    r = '{len: 0, mode: 0, fl: 0, r1: 0, r2: 0, ta: 0, reads: 0, tag: ""};
    if (op inside {8'hC0, 8'hC4, 8'hC8, 8'hF0, 8'hF4, 8'hF8}) begin
      r.len = 1; r.tag = "R1";
    end else if (op inside {8'h90, 8'h94, 8'h98, 8'h9C, 8'hA0, 8'hA4,
                            8'hA8, 8'hAC, 8'hB0, 8'hB4, 8'hB8}) begin
      r.len = 2; r.r1 = b1[7:4]; r.r2 = b1[3:0]; r.tag = "R2";
    end else begin
      n = op[1]; i = op[0]; xx = b1[7]; bb = b1[6]; p = b1[5]; e = b1[4];
      r.len = e ? 3'd4 : 3'd3;
      f12 = {b1[3:0], ib[15:8]};
      off = e ? ib[19:0] : {8'h00, f12};
      base = '0;
      if (bb && !p) begin base = b; r.tag = "R4"; end
      else if (p && !bb) begin
        base = pc + AW'(r.len); r.tag = "R5";
        if (!e) off = {{8{f12[11]}}, f12};
      end else r.tag = "R6";
      ta = base + off + (xx ? x : '0);
      if (xx) r.tag = {r.tag, " R7"};
      if (n && !i) begin
        w = {mb(ta), mb(ta + 1), mb(ta + 2)};
        ta = w[AW-1:0]; r.reads = 3; r.tag = {r.tag, " R9 R10"};
      end
      r.ta = ta; r.mode = {n, i}; r.fl = {n, i, xx, bb, p, e};
      r.tag = {r.tag, " R3 R8"};
    end
    return r;
  endfunction

  // memory model: data appears RD_LAT edges after a grant
  logic [7:0] pipe [LAT];
  always @(posedge clk) begin
    pipe[0] <= (mem_req && mem_gnt) ? mb(mem_addr) : 8'h00;
    for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
    if (mem_req && mem_gnt) mem_acc <= mem_acc + 1;
  end
  assign mem_rdata = pipe[LAT-1];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // output collector with random back-pressure
  initial begin
    forever begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      mem_gnt   = ($urandom % 3) != 0;
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) chk("R11 unexpected output", 1, 0);
        else begin
          exp_t e;
          logic ok;
          e = q.pop_front();
          ok = (out_len === e.len) && (out_mode === e.mode) && (out_flags === e.fl) &&
               (out_r1 === e.r1) && (out_r2 === e.r2) && (out_ta === e.ta);
          n_cmp++;
          if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual len=%0d mode=%b fl=%b r=%h/%h ta=%h expected len=%0d mode=%b fl=%b r=%h/%h ta=%h",
                     e.tag, out_len, out_mode, out_flags, out_r1, out_r2, out_ta,
                     e.len, e.mode, e.fl, e.r1, e.r2, e.ta);
          end
          chk("R8 read count", 32'(mem_acc - acc_mark), 32'(e.reads));
          acc_mark = mem_acc;
        end
      end
    end
  end

  task automatic send(input logic [31:0] ib, input logic [AW-1:0] pc,
                      input logic [AW-1:0] b, input logic [AW-1:0] x);
    exp_t e;
    @(negedge clk);
    in_bytes = ib; in_pc = pc; reg_b = b; reg_x = x; in_valid = 1'b1;
    e = model(ib, pc, b, x);
    q.push_back(e);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 busy after accept", 32'(in_ready), 0);
    if (e.reads == 0) chk("R12 result next cycle", 32'(out_valid), 1);
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  localparam logic [7:0] ONE_OPS [6] = '{8'hC0, 8'hC4, 8'hC8, 8'hF0, 8'hF4, 8'hF8};
  localparam logic [7:0] TWO_OPS [4] = '{8'h90, 8'hA4, 8'hB0, 8'hB8};

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk("R11 reset out_valid", 32'(out_valid), 0);
    chk("R11 reset mem_req", 32'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready after reset", 32'(in_ready), 1);

    send(32'hC4000000, 20'h00100, 20'h0, 20'h0);               // R1 one byte
    send(32'hAC350000, 20'h00100, 20'h0, 20'h0);               // R2 registers
    send(32'h03280000, 20'h00010, 20'h0, 20'h0);               // R5 -2048 wrap
    send(32'h034FFF00, 20'h0, 20'hFFF00, 20'h0);               // R4 max disp, wrap
    send(32'h039FFFFF, 20'h0, 20'h0, 20'h00005);               // R7 format 4 wrap
    send(32'h01101234, 20'h0, 20'h0, 20'h0);                   // R8 immediate
    send(32'h021FFFFF, 20'h0, 20'h0, 20'h0);                   // R9 read wraps
    send(32'h036A5500, 20'h00200, 20'h11111, 20'h0);           // R6 b=p=1
    send(32'h03300000, 20'hFFFFC, 20'h0, 20'h0);               // R5 format 4 field

    for (int t = 0; t < 400; t++) begin
      logic [31:0] ib;
      int k;
      ib = $urandom;
      k = $urandom % 10;
      if (k == 0) ib[31:24] = ONE_OPS[$urandom % 6];
      else if (k == 1) ib[31:24] = TWO_OPS[$urandom % 4];
      send(ib, AW'($urandom), AW'($urandom), AW'($urandom));
    end

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule